// File: doc/BRIEF.md
# Regular and Injected Conversion Sequencer

This block steps one sample-and-convert engine through a programmed list of channels. A regular list of up to sixteen entries is read in index order. Each entry names a channel and carries its own sampling-time code. The list runs once and stops, or it wraps and repeats until the block is disabled. A list of one entry gives single-channel operation. Every conversion is a sampling phase of the selected length followed by a fixed conversion phase. The block drives the channel select and the two phase strobes, and it captures the converter result on the last conversion tick.

A second, short injected list of up to four entries has priority. It is started by an external event input or by a software input. Starting it abandons the regular conversion in flight. When the injected group ends, the abandoned regular entry is sampled again from the start and the list carries on. Each injected result is kept in its own slot. Triggers that hit a group which is already running are dropped and latch an error flag.

All time is counted in ticks of a clock that runs at twice the converter clock. Half-cycle sampling times therefore become whole tick counts: 1.5 cycles is 3 ticks, and the 12.5-cycle conversion is 25 ticks.

Top module: `conv_sequencer`

## Requirements
- R1: While and just after reset, busy, trig_err, both strobes, both end pulses, chan_sel, reg_data and every injected slot are zero.
- R2: The 2-bit sampling code of an entry sets how long sample_strobe stays high: code 0 gives 3 ticks, code 1 gives 15, code 2 gives 27 and code 3 gives 57 (1.5, 7.5, 13.5 and 28.5 converter cycles). sample_strobe is then followed by exactly 25 ticks of convert_strobe. chan_sel shows the entry's channel throughout both phases.
- R3: reg_eoc is a one-tick pulse in the tick after the last conversion tick of a regular entry, and reg_data holds the conv_result present on that last tick. reg_data changes at no other time. With reg_start high at a clock edge, the first end pulse comes code-length + 26 ticks after that edge's sampling tick.
- R4: Regular entries run in index order from 0 to reg_count (reg_count holds length minus one). Channel numbers may be in any order and may repeat. Each following entry starts sampling in the same tick that reg_eoc is high.
- R5: With cont_mode low, the block goes idle after entry reg_count: busy falls, and no strobe or end pulse follows.
- R6: With cont_mode high, entry 0 follows entry reg_count and the list keeps repeating.
- R7: One tick after enable is seen low, busy and both strobes are low. reg_start and the injected triggers are ignored while enable is low.
- R8: A high level on inj_ext_trig or on inj_sw_trig at a clock edge starts the injected entries 0 to inj_count at once. It abandons any regular conversion in flight without an end pulse and without changing reg_data.
- R9: inj_eoc is a single one-tick pulse after the last injected entry. It never coincides with reg_eoc. The result of injected entry i lands in inj_data bits [i*12 +: 12].
- R10: After the injected group, the abandoned regular entry is sampled again for its full sampling time, starting in the inj_eoc tick. The list then carries on from that entry.
- R11: A trigger for a group that is already running (injected trigger during the injected group; reg_start during or while waiting for the regular list) is ignored and does not change that group's timing. It sets trig_err, which stays high until reset.
- R12: A reg_start that arrives while the injected group runs, with no regular work waiting, is held. Regular entry 0 then starts sampling in the inj_eoc tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the converter clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sequencer run enable; low forces idle |
| cont_mode | input | 1 | 1 = regular list repeats, 0 = runs once |
| reg_start | input | 1 | Start request for the regular list |
| inj_ext_trig | input | 1 | External-event start of the injected list |
| inj_sw_trig | input | 1 | Software start of the injected list |
| reg_count | input | 4 | Regular list length minus one |
| reg_chans | input | 80 | Channel of regular entry i at [i*5 +: 5] |
| reg_codes | input | 32 | Sampling code of regular entry i at [i*2 +: 2] |
| inj_count | input | 2 | Injected list length minus one |
| inj_chans | input | 20 | Channel of injected entry i at [i*5 +: 5] |
| inj_codes | input | 8 | Sampling code of injected entry i at [i*2 +: 2] |
| conv_result | input | 12 | Converter output, taken on the last conversion tick |
| chan_sel | output | 5 | Channel of the entry being handled, 0 when idle |
| sample_strobe | output | 1 | High during the sampling phase |
| convert_strobe | output | 1 | High during the conversion phase |
| reg_data | output | 12 | Last regular result |
| reg_eoc | output | 1 | Regular entry end pulse |
| inj_data | output | 48 | Injected result slots, slot i at [i*12 +: 12] |
| inj_eoc | output | 1 | Injected group end pulse |
| trig_err | output | 1 | Sticky flag for a trigger dropped on a running group |
| busy | output | 1 | A group is running or regular work is waiting |

## Verification
A wrong phase counter shows at once as a strobe width that is off. It also moves every following end pulse by the same number of ticks, so an error in one entry spreads into the timing of the whole list. A wrong list index or a lost resume point shows on chan_sel in the next sampling phase, and in the next result, within one conversion of the fault. A bad pending or busy decision shows as a missing end pulse, an extra one, or an error flag. Each scenario checks the end-pulse time against a tick count derived from the codes, together with the strobe widths, the channel and the result value.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    localparam int CH_W       = 5;
    localparam int CODE_W     = 2;
    localparam int CNT_W      = 6;
    localparam int CONV_TICKS = 25;

    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_CONV
    } phase_e;

    typedef enum logic {
        GRP_REG,
        GRP_INJ
    } group_e;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] code;
    } entry_t;

    // Last tick index of the sampling phase (ticks are half converter cycles).
    function automatic logic [CNT_W-1:0] samp_last(input logic [CODE_W-1:0] code);
        case (code)
            2'd0:    samp_last = 6'd2;
            2'd1:    samp_last = 6'd14;
            2'd2:    samp_last = 6'd26;
            default: samp_last = 6'd56;
        endcase
    endfunction

endpackage

// File: rtl/convseq_entry_sel.sv
module convseq_entry_sel
    import convseq_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N*CH_W-1:0]   chans_i,
    input  logic [N*CODE_W-1:0] codes_i,
    input  logic [IW-1:0]       idx_i,
    output entry_t              entry_o
);

    entry_t table_q [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign table_q[g].ch   = chans_i[g*CH_W +: CH_W];
        assign table_q[g].code = codes_i[g*CODE_W +: CODE_W];
    end

    assign entry_o = table_q[idx_i];

endmodule

// File: rtl/convseq_inj_bank.sv
module convseq_inj_bank #(
    parameter int N      = 4,
    parameter int DATA_W = 12,
    localparam int IW    = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_en,
    input  logic [IW-1:0]       cap_idx,
    input  logic [DATA_W-1:0]   din,
    output logic [N*DATA_W-1:0] slots_o
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots_o[g*DATA_W +: DATA_W] <= '0;
            end else if (cap_en && cap_idx == IW'(g)) begin
                slots_o[g*DATA_W +: DATA_W] <= din;
            end
        end
    end

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import convseq_pkg::*;
#(
    parameter int REG_N  = 16,
    parameter int INJ_N  = 4,
    parameter int DATA_W = 12,
    localparam int REG_IW = $clog2(REG_N),
    localparam int INJ_IW = $clog2(INJ_N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    cont_mode,
    input  logic                    reg_start,
    input  logic                    inj_ext_trig,
    input  logic                    inj_sw_trig,
    input  logic [REG_IW-1:0]       reg_count,
    input  logic [REG_N*CH_W-1:0]   reg_chans,
    input  logic [REG_N*CODE_W-1:0] reg_codes,
    input  logic [INJ_IW-1:0]       inj_count,
    input  logic [INJ_N*CH_W-1:0]   inj_chans,
    input  logic [INJ_N*CODE_W-1:0] inj_codes,
    input  logic [DATA_W-1:0]       conv_result,
    output logic [CH_W-1:0]         chan_sel,
    output logic                    sample_strobe,
    output logic                    convert_strobe,
    output logic [DATA_W-1:0]       reg_data,
    output logic                    reg_eoc,
    output logic [INJ_N*DATA_W-1:0] inj_data,
    output logic                    inj_eoc,
    output logic                    trig_err,
    output logic                    busy
);

    phase_e              phase, nphase;
    group_e              grp, ngrp;
    logic [REG_IW-1:0]   idx, nidx;
    logic [REG_IW-1:0]   resume, nresume;
    logic [CNT_W-1:0]    cnt, ncnt;
    logic                reg_pend, npend;
    logic                nerr;
    logic                reg_cap, inj_cap, inj_last;

    entry_t reg_ent, inj_ent, cur;

    convseq_entry_sel #(.N(REG_N)) u_reg_sel (
        .chans_i (reg_chans),
        .codes_i (reg_codes),
        .idx_i   (idx),
        .entry_o (reg_ent)
    );

    convseq_entry_sel #(.N(INJ_N)) u_inj_sel (
        .chans_i (inj_chans),
        .codes_i (inj_codes),
        .idx_i   (idx[INJ_IW-1:0]),
        .entry_o (inj_ent)
    );

    convseq_inj_bank #(.N(INJ_N), .DATA_W(DATA_W)) u_inj_bank (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (inj_cap),
        .cap_idx (idx[INJ_IW-1:0]),
        .din     (conv_result),
        .slots_o (inj_data)
    );

    logic active, inj_busy, reg_busy, inj_req, samp_done, conv_done;

    assign cur       = (grp == GRP_INJ) ? inj_ent : reg_ent;
    assign active    = (phase != PH_IDLE);
    assign inj_busy  = active && (grp == GRP_INJ);
    assign reg_busy  = (active && (grp == GRP_REG)) || reg_pend;
    assign inj_req   = inj_ext_trig || inj_sw_trig;
    assign samp_done = (phase == PH_SAMPLE) && (cnt == samp_last(cur.code));
    assign conv_done = (phase == PH_CONV) && (cnt == CONV_LAST);

    always_comb begin
        nphase   = phase;
        ngrp     = grp;
        nidx     = idx;
        ncnt     = cnt + 1'b1;
        npend    = reg_pend;
        nresume  = resume;
        nerr     = trig_err;
        reg_cap  = 1'b0;
        inj_cap  = 1'b0;
        inj_last = 1'b0;
        if (!enable) begin
            nphase = PH_IDLE;
            npend  = 1'b0;
            ncnt   = '0;
        end else begin
            // advance the conversion in flight
            if (phase == PH_IDLE) begin
                ncnt = '0;
            end else if (samp_done) begin
                nphase = PH_CONV;
                ncnt   = '0;
            end else if (conv_done) begin
                ncnt   = '0;
                nphase = PH_SAMPLE;
                if (grp == GRP_REG) begin
                    reg_cap = 1'b1;
                    if (idx == reg_count) begin
                        nidx = '0;
                        if (!cont_mode) nphase = PH_IDLE;
                    end else begin
                        nidx = idx + 1'b1;
                    end
                end else begin
                    inj_cap = 1'b1;
                    if (idx == REG_IW'(inj_count)) begin
                        inj_last = 1'b1;
                        if (reg_pend) begin
                            ngrp  = GRP_REG;
                            nidx  = resume;
                            npend = 1'b0;
                        end else begin
                            nphase = PH_IDLE;
                        end
                    end else begin
                        nidx = idx + 1'b1;
                    end
                end
            end
            // regular start request
            if (reg_start) begin
                if (reg_busy) begin
                    nerr = 1'b1;
                end else if (nphase != PH_IDLE && ngrp == GRP_INJ) begin
                    npend   = 1'b1;
                    nresume = '0;
                end else begin
                    ngrp   = GRP_REG;
                    nidx   = '0;
                    nphase = PH_SAMPLE;
                    ncnt   = '0;
                end
            end
            // injected request has the last word
            if (inj_req) begin
                if (inj_busy) begin
                    nerr = 1'b1;
                end else begin
                    if (nphase != PH_IDLE && ngrp == GRP_REG) begin
                        npend   = 1'b1;
                        nresume = nidx;
                    end
                    ngrp   = GRP_INJ;
                    nidx   = '0;
                    nphase = PH_SAMPLE;
                    ncnt   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            grp      <= GRP_REG;
            idx      <= '0;
            resume   <= '0;
            cnt      <= '0;
            reg_pend <= 1'b0;
            trig_err <= 1'b0;
            reg_eoc  <= 1'b0;
            inj_eoc  <= 1'b0;
            reg_data <= '0;
        end else begin
            phase    <= nphase;
            grp      <= ngrp;
            idx      <= nidx;
            resume   <= nresume;
            cnt      <= ncnt;
            reg_pend <= npend;
            trig_err <= nerr;
            reg_eoc  <= reg_cap;
            inj_eoc  <= inj_last;
            if (reg_cap) reg_data <= conv_result;
        end
    end

    assign sample_strobe  = (phase == PH_SAMPLE);
    assign convert_strobe = (phase == PH_CONV);
    assign chan_sel       = active ? cur.ch : '0;
    assign busy           = active || reg_pend;

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              sample_strobe,
    input logic              convert_strobe,
    input logic [DATA_W-1:0] reg_data,
    input logic              reg_eoc,
    input logic              inj_eoc,
    input logic              trig_err,
    input logic              busy
);

    AST_CONV_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(convert_strobe) |-> $past(sample_strobe));                        // R2

    AST_SAMPLE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(convert_strobe) |-> ($past(sample_strobe, 2) && $past(sample_strobe, 3))); // R2

    AST_REG_EOC_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
        reg_eoc |-> $past(convert_strobe));                                     // R3

    AST_REG_DATA_ONLY_ON_EOC: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_data) |-> reg_eoc);                                        // R3

    AST_DISABLE_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !sample_strobe && !convert_strobe));              // R7

    AST_INJ_EOC_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
        inj_eoc |-> $past(convert_strobe));                                     // R9

    AST_EOC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({reg_eoc, inj_eoc}) <= 1);                                   // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        trig_err |=> trig_err);                                                 // R11

endmodule

bind conv_sequencer conv_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .sample_strobe  (sample_strobe),
    .convert_strobe (convert_strobe),
    .reg_data       (reg_data),
    .reg_eoc        (reg_eoc),
    .inj_eoc        (inj_eoc),
    .trig_err       (trig_err),
    .busy           (busy)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable, cont_mode, reg_start, inj_ext_trig, inj_sw_trig;
    logic [3:0]  reg_count;
    logic [79:0] reg_chans;
    logic [31:0] reg_codes;
    logic [1:0]  inj_count;
    logic [19:0] inj_chans;
    logic [7:0]  inj_codes;
    logic [11:0] conv_result;
    logic [4:0]  chan_sel;
    logic        sample_strobe, convert_strobe, reg_eoc, inj_eoc, trig_err, busy;
    logic [11:0] reg_data;
    logic [47:0] inj_data;
    logic [3:0]  stub_bias;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // converter stub: result encodes the selected channel and a per-test bias
    assign conv_result = {3'b101, stub_bias, chan_sel};

    conv_sequencer u_conv_sequencer (
        .clk(clk), .rst(rst), .enable(enable), .cont_mode(cont_mode),
        .reg_start(reg_start), .inj_ext_trig(inj_ext_trig), .inj_sw_trig(inj_sw_trig),
        .reg_count(reg_count), .reg_chans(reg_chans), .reg_codes(reg_codes),
        .inj_count(inj_count), .inj_chans(inj_chans), .inj_codes(inj_codes),
        .conv_result(conv_result), .chan_sel(chan_sel),
        .sample_strobe(sample_strobe), .convert_strobe(convert_strobe),
        .reg_data(reg_data), .reg_eoc(reg_eoc), .inj_data(inj_data),
        .inj_eoc(inj_eoc), .trig_err(trig_err), .busy(busy)
    );

    function automatic logic [11:0] expv(input logic [4:0] ch);
        return {3'b101, stub_bias, ch};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cyc >= WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        rst = 1'b1; enable = 1'b0; cont_mode = 1'b0; reg_start = 1'b0;
        inj_ext_trig = 1'b0; inj_sw_trig = 1'b0;
        reg_count = '0; reg_chans = '0; reg_codes = '0;
        inj_count = '0; inj_chans = '0; inj_codes = '0; stub_bias = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic set_reg(input int i, input logic [4:0] ch, input logic [1:0] code);
        reg_chans[i*5 +: 5] = ch;
        reg_codes[i*2 +: 2] = code;
    endtask

    task automatic set_inj(input int i, input logic [4:0] ch, input logic [1:0] code);
        inj_chans[i*5 +: 5] = ch;
        inj_codes[i*2 +: 2] = code;
    endtask

    // Waits for the chosen end pulse; counts strobe ticks before it and the other pulse.
    task automatic wait_eoc(input bit want_inj, output int at, output int ns, output int nc,
                            output int other, output logic [4:0] ch);
        bit hit = 0;
        int guard = 0;
        ns = 0; nc = 0; other = 0; ch = '0; at = -1;
        if (sample_strobe) begin ns++; ch = chan_sel; end
        if (convert_strobe) nc++;
        while (!hit && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (want_inj ? inj_eoc : reg_eoc) begin
                hit = 1;
                at  = cyc;
            end else begin
                if (want_inj ? reg_eoc : inj_eoc) other++;
                if (sample_strobe) begin ns++; ch = chan_sel; end
                if (convert_strobe) nc++;
            end
        end
    endtask

    task automatic quiet_window(input int n, output int strobes, output int eocs);
        strobes = 0; eocs = 0;
        repeat (n) begin
            @(negedge clk);
            if (sample_strobe || convert_strobe) strobes++;
            if (reg_eoc || inj_eoc) eocs++;
        end
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "trig_err", trig_err, 0);
        chk("R1", "strobes", {sample_strobe, convert_strobe}, 0);
        chk("R1", "end pulses", {reg_eoc, inj_eoc}, 0);
        chk("R1", "chan_sel", chan_sel, 0);
        chk("R1", "reg_data", reg_data, 0);
        chk("R1", "inj_data", inj_data, 0);
    endtask

    task automatic test_single_scan();
        int t0, at, ns, nc, oth, s, e;
        logic [4:0] ch;
        do_reset();
        stub_bias = 4'h2;
        set_reg(0, 5'd9, 2'd1);
        set_reg(1, 5'd3, 2'd0);
        set_reg(2, 5'd9, 2'd2);
        reg_count = 4'd2;
        t0 = cyc;
        reg_start = 1'b1; @(negedge clk); reg_start = 1'b0;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R3", "first end pulse delay", at - t0, 41);
        chk("R2", "code1 sample ticks", ns, 15);
        chk("R2", "conversion ticks", nc, 25);
        chk("R2", "entry0 channel", ch, 9);
        chk("R3", "entry0 result", reg_data, expv(5'd9));
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R4", "entry1 follows", at - t0, 28);
        chk("R2", "code0 sample ticks", ns, 3);
        chk("R4", "entry1 channel", ch, 3);
        chk("R3", "entry1 result", reg_data, expv(5'd3));
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R4", "entry2 follows", at - t0, 52);
        chk("R2", "code2 sample ticks", ns, 27);
        chk("R4", "repeated channel", ch, 9);
        quiet_window(100, s, e);
        chk("R5", "strobes after last entry", s, 0);
        chk("R5", "pulses after last entry", e, 0);
        chk("R5", "busy after last entry", busy, 0);
    endtask

    task automatic test_continuous_and_disable();
        int t0, at, ns, nc, oth, s, e;
        logic [4:0] ch;
        do_reset();
        stub_bias = 4'h3;
        cont_mode = 1'b1;
        set_reg(0, 5'd4, 2'd0);
        set_reg(1, 5'd17, 2'd0);
        reg_count = 4'd1;
        t0 = cyc;
        reg_start = 1'b1; @(negedge clk); reg_start = 1'b0;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R3", "cont first delay", at - t0, 29);
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R6", "cont second", at - t0, 28);
        chk("R6", "cont second channel", ch, 17);
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R6", "wrap timing", at - t0, 28);
        chk("R6", "wrap to entry0", ch, 4);
        chk("R6", "wrap result", reg_data, expv(5'd4));
        enable = 1'b0;
        @(negedge clk);
        chk("R7", "busy after disable", busy, 0);
        chk("R7", "strobes after disable", {sample_strobe, convert_strobe}, 0);
        reg_start = 1'b1; inj_sw_trig = 1'b1;
        @(negedge clk);
        reg_start = 1'b0; inj_sw_trig = 1'b0;
        quiet_window(60, s, e);
        chk("R7", "strobes with disabled starts", s, 0);
        chk("R7", "pulses with disabled starts", e, 0);
        chk("R7", "busy with disabled starts", busy, 0);
        chk("R7", "no error when disabled", trig_err, 0);
    endtask

    task automatic test_preempt();
        int t0, ti, at, ns, nc, oth, pre;
        logic [4:0] ch;
        do_reset();
        stub_bias = 4'h9;
        set_reg(0, 5'd1, 2'd3);
        set_reg(1, 5'd2, 2'd0);
        reg_count = 4'd1;
        set_inj(0, 5'd20, 2'd0);
        set_inj(1, 5'd21, 2'd1);
        inj_count = 2'd1;
        t0 = cyc;
        reg_start = 1'b1; @(negedge clk); reg_start = 1'b0;
        pre = 0;
        repeat (9) begin
            @(negedge clk);
            if (reg_eoc || inj_eoc) pre++;
        end
        chk("R8", "no pulse before trigger", pre, 0);
        ti = cyc;
        inj_ext_trig = 1'b1; @(negedge clk); inj_ext_trig = 1'b0;
        chk("R8", "injected entry0 channel", chan_sel, 20);
        wait_eoc(1, at, ns, nc, oth, ch);
        chk("R8", "injected group delay", at - ti, 69);
        chk("R8", "abandoned regular gives no pulse", oth, 0);
        chk("R8", "reg_data untouched", reg_data, 0);
        chk("R9", "slot0 result", inj_data[0 +: 12], expv(5'd20));
        chk("R9", "slot1 result", inj_data[12 +: 12], expv(5'd21));
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R10", "resumed entry delay", at - t0, 82);
        chk("R10", "resumed full sampling", ns, 57);
        chk("R10", "resumed channel", ch, 1);
        chk("R10", "resumed result", reg_data, expv(5'd1));
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R10", "list continues", at - t0, 28);
        chk("R10", "list continues channel", ch, 2);
        @(negedge clk);
        chk("R5", "idle after resumed list", busy, 0);
    endtask

    task automatic test_errors();
        int t0, at, ns, nc, oth, s, e;
        logic [4:0] ch;
        do_reset();
        stub_bias = 4'h6;
        set_inj(0, 5'd5, 2'd1);
        inj_count = 2'd0;
        set_reg(0, 5'd6, 2'd0);
        reg_count = 4'd0;
        t0 = cyc;
        inj_sw_trig = 1'b1; @(negedge clk); inj_sw_trig = 1'b0;
        chk("R11", "no error on first trigger", trig_err, 0);
        repeat (3) @(negedge clk);
        inj_ext_trig = 1'b1; @(negedge clk); inj_ext_trig = 1'b0;
        chk("R11", "error on repeated injected trigger", trig_err, 1);
        reg_start = 1'b1; @(negedge clk); reg_start = 1'b0;
        wait_eoc(1, at, ns, nc, oth, ch);
        chk("R11", "injected timing unaffected", at - t0, 41);
        chk("R9", "single slot result", inj_data[0 +: 12], expv(5'd5));
        t0 = at;
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R12", "held regular start", at - t0, 28);
        chk("R12", "held regular channel", ch, 6);

        do_reset();
        set_reg(0, 5'd6, 2'd3);
        reg_count = 4'd0;
        t0 = cyc;
        reg_start = 1'b1; @(negedge clk); reg_start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", "no error yet", trig_err, 0);
        reg_start = 1'b1; @(negedge clk); reg_start = 1'b0;
        chk("R11", "error on repeated regular start", trig_err, 1);
        wait_eoc(0, at, ns, nc, oth, ch);
        chk("R11", "regular timing unaffected", at - t0, 83);
        quiet_window(50, s, e);
        chk("R11", "repeat start not queued", e, 0);
        chk("R11", "error stays set", trig_err, 1);
    endtask

    initial begin
        test_reset();
        test_single_scan();
        test_continuous_and_disable();
        test_preempt();
        test_errors();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule